// File: doc/BRIEF.md
# Sliced-Access General Register Bank

This block holds eight 32-bit general-purpose registers and serves two combinational read ports and one clocked write port. Every access carries a register index and a two-bit size code. The size code selects the full word, the lower 16-bit half, bits 7:0 or bits 15:8.

A narrow write replaces only the selected slice and leaves every other bit of the register as it was. A narrow read places the selected slice in the low bits of the 32-bit read bus and fills the rest with zeros. Byte access is allowed only on registers 0 to 3. On registers 4 to 7 a byte-size access raises an illegal flag on that port. A flagged write changes nothing, and a flagged read returns zero.

A read of the register that is being written in the same cycle returns the value the register will hold after the write. A pipeline can therefore issue a producer and its consumer back to back.

Top module: `gpr_bank`

## Requirements
- R1: While reset is low and after it is released, every register holds zero, so every read returns zero.
- R2: A write with size code 3 (full word) replaces all 32 bits of the indexed register with wr_data.
- R3: A write with size code 2 (half) loads wr_data[15:0] into bits 15:0 and keeps bits 31:16.
- R4: On registers 0 to 3, size code 0 loads wr_data[7:0] into bits 7:0 and keeps bits 31:8. Size code 1 loads wr_data[7:0] into bits 15:8 and keeps all other bits.
- R5: Reads zero-extend the selected slice onto the 32-bit bus. Code 0 returns bits 7:0, code 1 returns bits 15:8, code 2 returns bits 15:0 and code 3 returns the whole word.
- R6: Size code 0 or 1 on registers 4 to 7 is illegal. A write with wr_en high and such a code raises wr_illegal and leaves the register unchanged. A read with such a code raises that port's illegal flag and returns zero.
- R7: When a legal write targets the register that a read port selects in the same cycle, the port returns the merged new value, sliced by its own size code.
- R8: The two read ports are independent and can select different registers and sizes in the same cycle.
- R9: With wr_en low, no register changes and wr_illegal stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_size | input | 2 | Write size code (0 bits 7:0, 1 bits 15:8, 2 half, 3 word) |
| wr_data | input | 32 | Write data; narrow sizes take their low bits |
| wr_illegal | output | 1 | Write requested with a byte size on registers 4 to 7 |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 byte size on registers 4 to 7 |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 byte size on registers 4 to 7 |

## Verification
A write and a read of the same register can fall in the same cycle. The bench provokes this by writing a register while both read ports select it, using different size codes on the two ports. It also writes a narrow slice while a port reads the full word. The scoreboard expects the slice merged into the old contents and then cut by each port's own size. An illegal byte write is also paired with a same-cycle read of its target, and that read must show the old contents.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        ACC_LO8 = 2'd0,
        ACC_HI8 = 2'd1,
        ACC_W16 = 2'd2,
        ACC_W32 = 2'd3
    } acc_size_e;

endpackage

// File: rtl/gpr_access_check.sv
`timescale 1ns/1ps
module gpr_access_check
    import gpr_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int BYTE_REGS = 4,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    output logic             illegal
);

    logic is_byte;
    logic no_byte_reg;

    always_comb begin
        is_byte     = (size == ACC_LO8) || (size == ACC_HI8);
        no_byte_reg = (int'(idx) >= BYTE_REGS);
        illegal     = is_byte && no_byte_reg;
    end

endmodule

// File: rtl/gpr_slice_merge.sv
`timescale 1ns/1ps
module gpr_slice_merge
    import gpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        merged = old_val;
        case (size)
            ACC_LO8: merged[BYTE_W-1:0]      = wdata[BYTE_W-1:0];
            ACC_HI8: merged[HALF_W-1:BYTE_W] = wdata[BYTE_W-1:0];
            ACC_W16: merged[HALF_W-1:0]      = wdata[HALF_W-1:0];
            ACC_W32: merged                  = wdata;
            default: merged                  = old_val;
        endcase
    end

endmodule

// File: rtl/gpr_slice_read.sv
`timescale 1ns/1ps
module gpr_slice_read
    import gpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  acc_size_e         size,
    input  logic              illegal,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (!illegal) begin
            case (size)
                ACC_LO8: rdata = {{(DATA_W-BYTE_W){1'b0}}, value[BYTE_W-1:0]};
                ACC_HI8: rdata = {{(DATA_W-BYTE_W){1'b0}}, value[HALF_W-1:BYTE_W]};
                ACC_W16: rdata = {{(DATA_W-HALF_W){1'b0}}, value[HALF_W-1:0]};
                ACC_W32: rdata = value;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpr_bank.sv
`timescale 1ns/1ps
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int BYTE_REGS = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_size,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_illegal,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_size,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_illegal
);

    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic                            wr_bad;
    logic                            wr_ok;
    logic [DATA_W-1:0]               wr_merged;

    logic [IDX_W-1:0]  rd_idx  [NUM_RD];
    acc_size_e         rd_size [NUM_RD];
    logic              rd_bad  [NUM_RD];
    logic [DATA_W-1:0] rd_src  [NUM_RD];
    logic [DATA_W-1:0] rd_out  [NUM_RD];

    assign regs_q = state_q.regs;

    // write-side legality and slice merge
    gpr_access_check #(
        .NUM_REGS  (NUM_REGS),
        .BYTE_REGS (BYTE_REGS)
    ) u_wr_check (
        .idx     (wr_idx),
        .size    (acc_size_e'(wr_size)),
        .illegal (wr_bad)
    );

    gpr_slice_merge #(
        .DATA_W (DATA_W)
    ) u_wr_merge (
        .old_val (regs_q[wr_idx]),
        .wdata   (wr_data),
        .size    (acc_size_e'(wr_size)),
        .merged  (wr_merged)
    );

    assign wr_ok      = wr_en && !wr_bad;
    assign wr_illegal = wr_en && wr_bad;

    // read ports
    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;
    assign rd_size[0] = acc_size_e'(rd0_size);
    assign rd_size[1] = acc_size_e'(rd1_size);

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        gpr_access_check #(
            .NUM_REGS  (NUM_REGS),
            .BYTE_REGS (BYTE_REGS)
        ) u_rd_check (
            .idx     (rd_idx[g]),
            .size    (rd_size[g]),
            .illegal (rd_bad[g])
        );

        // same-cycle bypass of the merged write value
        always_comb begin
            if (wr_ok && (rd_idx[g] == wr_idx)) begin
                rd_src[g] = wr_merged;
            end else begin
                rd_src[g] = regs_q[rd_idx[g]];
            end
        end

        gpr_slice_read #(
            .DATA_W (DATA_W)
        ) u_rd_slice (
            .value   (rd_src[g]),
            .size    (rd_size[g]),
            .illegal (rd_bad[g]),
            .rdata   (rd_out[g])
        );
    end

    assign rd0_data    = rd_out[0];
    assign rd1_data    = rd_out[1];
    assign rd0_illegal = rd_bad[0];
    assign rd1_illegal = rd_bad[1];

    // next-state
    always_comb begin
        state_d = state_q;
        if (wr_ok) begin
            state_d.regs[wr_idx] = wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/gpr_bank_chk.sv
`timescale 1ns/1ps
module gpr_bank_chk
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [1:0]                      wr_size,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            wr_illegal,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic [1:0]                      rd0_size,
    input logic [DATA_W-1:0]               rd0_data,
    input logic                            rd0_illegal,
    input logic [IDX_W-1:0]                rd1_idx,
    input logic [1:0]                      rd1_size,
    input logic [DATA_W-1:0]               rd1_data,
    input logic                            rd1_illegal,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_rst
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (regs_q[r] == '0));
    end

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_size == ACC_W32)
        |=> regs_q[$past(wr_idx)] == $past(wr_data));

    // R3
    half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_size == ACC_W16)
        |=> (regs_q[$past(wr_idx)][DATA_W-1:16] == $past(regs_q[wr_idx][DATA_W-1:16]))
            && (regs_q[$past(wr_idx)][15:0] == $past(wr_data[15:0])));

    // R4
    lo_byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_illegal && (wr_size == ACC_LO8)
        |=> (regs_q[$past(wr_idx)][DATA_W-1:8] == $past(regs_q[wr_idx][DATA_W-1:8]))
            && (regs_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));

    // R4
    hi_byte_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_illegal && (wr_size == ACC_HI8)
        |=> (regs_q[$past(wr_idx)][15:8] == $past(wr_data[7:0]))
            && (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0]))
            && (regs_q[$past(wr_idx)][DATA_W-1:16] == $past(regs_q[wr_idx][DATA_W-1:16])));

    // R6
    bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> regs_q[$past(wr_idx)] == $past(regs_q[wr_idx]));

    // R6
    bad_read0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_illegal |-> rd0_data == '0);

    // R6
    bad_read1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_illegal |-> rd1_data == '0);

    // R7
    bypass0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_illegal && (rd0_idx == wr_idx) && (rd0_size == ACC_W32)
        |=> regs_q[$past(rd0_idx)] == $past(rd0_data));

    // R7
    bypass1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_illegal && (rd1_idx == wr_idx) && (rd1_size == ACC_W32)
        |=> regs_q[$past(rd1_idx)] == $past(rd1_data));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

    // R9
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);

endmodule

bind gpr_bank gpr_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_size     (wr_size),
    .wr_data     (wr_data),
    .wr_illegal  (wr_illegal),
    .rd0_idx     (rd0_idx),
    .rd0_size    (rd0_size),
    .rd0_data    (rd0_data),
    .rd0_illegal (rd0_illegal),
    .rd1_idx     (rd1_idx),
    .rd1_size    (rd1_size),
    .rd1_data    (rd1_data),
    .rd1_illegal (rd1_illegal),
    .regs_q      (regs_q)
);

// File: tb/sim_gpr_bank.sv
`timescale 1ns/1ps
module sim_gpr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_illegal;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = 2'd3;
    logic [31:0] rd0_data;
    logic        rd0_illegal;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = 2'd3;
    logic [31:0] rd1_data;
    logic        rd1_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] d0;
        logic        i0;
        logic [31:0] d1;
        logic        i1;
        logic        wi;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model [8];

    always #5 clk = ~clk;

    gpr_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
        .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
    );

    function automatic logic bad_acc(input int idx, input logic [1:0] sz);
        return (idx >= 4) && (sz < 2'd2);
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [1:0] sz,
                                              input logic [31:0] d);
        case (sz)
            2'd0:    return {old[31:8], d[7:0]};
            2'd1:    return {old[31:16], d[7:0], old[7:0]};
            2'd2:    return {old[31:16], d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] v, input int idx,
                                             input logic [1:0] sz);
        if (bad_acc(idx, sz)) return 32'h0;
        case (sz)
            2'd0:    return {24'h0, v[7:0]};
            2'd1:    return {24'h0, v[15:8]};
            2'd2:    return {16'h0, v[15:0]};
            default: return v;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected values pushed to the scoreboard
    task automatic step(input logic we, input int widx, input logic [1:0] wsz,
                        input logic [31:0] wd, input int a, input logic [1:0] asz,
                        input int b, input logic [1:0] bsz, input string req, input bit chk);
        logic [31:0] nxt [8];
        logic        wbad;
        exp_t        e;
        @(negedge clk);
        wr_en    = we;
        wr_idx   = 3'(widx);
        wr_size  = wsz;
        wr_data  = wd;
        rd0_idx  = 3'(a);
        rd0_size = asz;
        rd1_idx  = 3'(b);
        rd1_size = bsz;
        wbad = bad_acc(widx, wsz);
        for (int k = 0; k < 8; k++) nxt[k] = model[k];
        if (we && !wbad) nxt[widx] = exp_merge(model[widx], wsz, wd);
        if (chk) begin
            e.d0  = exp_read(nxt[a], a, asz);
            e.i0  = bad_acc(a, asz);
            e.d1  = exp_read(nxt[b], b, bsz);
            e.i1  = bad_acc(b, bsz);
            e.wi  = we && wbad;
            e.req = req;
            sb.push_back(e);
        end
        for (int k = 0; k < 8; k++) model[k] = nxt[k];
    endtask

    // monitor: compares away from the rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(e.req, "rd0_data",    rd0_data,           e.d0);
                check(e.req, "rd0_illegal", {31'h0, rd0_illegal}, {31'h0, e.i0});
                check(e.req, "rd1_data",    rd1_data,           e.d1);
                check(e.req, "rd1_illegal", {31'h0, rd1_illegal}, {31'h0, e.i1});
                check(e.req, "wr_illegal",  {31'h0, wr_illegal},  {31'h0, e.wi});
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        step(0, 0, 2'd3, 32'h0, 0, 2'd3, 7, 2'd3, "R1", 1);
        step(0, 0, 2'd3, 32'h0, 3, 2'd3, 4, 2'd3, "R1", 1);

        // R2: full-word writes
        step(1, 0, 2'd3, 32'hDEADBEEF, 1, 2'd3, 2, 2'd3, "R2", 1);
        step(1, 6, 2'd3, 32'hCAFEF00D, 0, 2'd3, 6, 2'd3, "R2", 1);
        step(0, 0, 2'd3, 32'h0, 0, 2'd3, 6, 2'd3, "R2", 1);

        // R3: half write keeps upper bits
        step(1, 1, 2'd3, 32'h11223344, 0, 2'd3, 0, 2'd3, "R3", 0);
        step(1, 1, 2'd2, 32'hAAAA5555, 0, 2'd3, 0, 2'd3, "R3", 0);
        step(1, 5, 2'd2, 32'hFFFF1234, 0, 2'd3, 0, 2'd3, "R3", 0);
        step(0, 0, 2'd3, 32'h0, 1, 2'd3, 5, 2'd3, "R3", 1);

        // R4: byte writes on byte-capable registers
        step(1, 2, 2'd3, 32'h01020304, 0, 2'd3, 0, 2'd3, "R4", 0);
        step(1, 2, 2'd0, 32'hFFFFFFEE, 0, 2'd3, 0, 2'd3, "R4", 0);
        step(0, 0, 2'd3, 32'h0, 2, 2'd3, 2, 2'd3, "R4", 1);
        step(1, 2, 2'd1, 32'h00009977, 0, 2'd3, 0, 2'd3, "R4", 0);
        step(0, 0, 2'd3, 32'h0, 2, 2'd3, 1, 2'd3, "R4", 1);

        // R5: narrow reads zero-extend
        step(0, 0, 2'd3, 32'h0, 2, 2'd0, 2, 2'd1, "R5", 1);
        step(0, 0, 2'd3, 32'h0, 1, 2'd2, 0, 2'd1, "R5", 1);
        step(0, 0, 2'd3, 32'h0, 6, 2'd2, 0, 2'd0, "R5", 1);

        // R6: byte access to registers 4..7
        step(1, 5, 2'd0, 32'h000000AB, 5, 2'd3, 6, 2'd1, "R6", 1);
        step(1, 7, 2'd1, 32'h000000CD, 7, 2'd3, 4, 2'd0, "R6", 1);
        step(0, 0, 2'd3, 32'h0, 5, 2'd3, 7, 2'd3, "R6", 1);

        // R7: same-cycle read of the register being written
        step(1, 3, 2'd3, 32'h87654321, 3, 2'd3, 3, 2'd1, "R7", 1);
        step(1, 3, 2'd0, 32'h0000005A, 3, 2'd3, 3, 2'd2, "R7", 1);
        step(1, 4, 2'd2, 32'h0000BEEF, 4, 2'd3, 4, 2'd2, "R7", 1);
        step(1, 3, 2'd1, 32'h000000C3, 3, 2'd3, 0, 2'd3, "R7", 1);

        // R8: independent ports
        step(0, 0, 2'd3, 32'h0, 0, 2'd1, 1, 2'd0, "R8", 1);
        step(0, 0, 2'd3, 32'h0, 6, 2'd3, 3, 2'd0, "R8", 1);

        // R9: disabled write has no effect
        step(0, 1, 2'd3, 32'h5A5A5A5A, 1, 2'd3, 6, 2'd3, "R9", 1);
        step(0, 6, 2'd0, 32'h5A5A5A5A, 1, 2'd3, 6, 2'd3, "R9", 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule